// File: doc/BRIEF.md
# RISC Integer ALU with Opcode Decoder

A purely combinational arithmetic and logic unit for a 32-bit RISC core whose instructions come in register, immediate and jump formats. It receives the 6-bit primary opcode, the 6-bit function field, the 5-bit shift amount, both register operands and the 16-bit immediate. It decodes these fields into an operation, builds the second operand, and returns a 32-bit result together with a signed-overflow indication.

The second operand is the rt register, the immediate widened with its sign, the immediate widened with zeros, or the immediate moved into the upper half. The unit only reports overflow. The surrounding pipeline decides whether to trap. Any encoding outside the supported set produces a zero result and raises an illegal-operation flag. Register file, memory, branches and exception handling belong to the surrounding core.

Top module: `risc_alu`

## Requirements
- R1: With opcode 0x00 the function field selects the operation: 0x20 add, 0x21 add-unsigned, 0x22 subtract, 0x23 subtract-unsigned, 0x24 and, 0x25 or, 0x27 nor, 0x2a set-less-than, 0x2b set-less-than-unsigned, 0x00 shift-left-logical, 0x02 shift-right-logical.
- R2: Immediate opcodes: 0x08 add-immediate, 0x09 add-immediate-unsigned, 0x0a set-less-than-immediate, 0x0b set-less-than-immediate-unsigned, 0x0c and-immediate, 0x0d or-immediate, 0x0f load-upper-immediate; each uses rs as the first operand.
- R3: Opcodes 0x08, 0x09, 0x0a and 0x0b copy immediate bit 15 into result-operand bits 31:16. Opcodes 0x0c and 0x0d put zeros there.
- R4: Opcode 0x0f returns the immediate in bits 31:16 and zeros in bits 15:0.
- R5: Set-less-than (funct 0x2a, opcode 0x0a) compares as two's complement and returns exactly 1 or 0.
- R6: Set-less-than-unsigned (funct 0x2b, opcode 0x0b) compares as unsigned and returns 1 or 0. Opcode 0x0b sign-extends its immediate before the compare.
- R7: For add (0x20), add-immediate (0x08) and subtract (0x22), the overflow output is 1 exactly when the two's-complement result does not fit in 32 bits. The result is always the low 32 bits of the sum or difference.
- R8: Add-unsigned, add-immediate-unsigned, subtract-unsigned and all non-arithmetic operations never assert overflow. Their arithmetic results wrap modulo 2^32.
- R9: Shift-left-logical and shift-right-logical shift rt by the shamt field and fill the vacated bits with zeros.
- R10: An unsupported opcode, or an unsupported function code under opcode 0x00, gives result 0, overflow 0 and illegal 1. Supported encodings give illegal 0.
- R11: And, or and nor (register forms) and and-immediate and or-immediate compute the bitwise function of their operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function field, used when opcode is 0 |
| shamt_i | input | 5 | Shift amount |
| rs_i | input | 32 | First register operand |
| rt_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow of a trapping add or subtract |
| illegal_o | output | 1 | Unsupported opcode or function code |

## Verification
The embedded assertions hold on every evaluation:
- an illegal encoding yields a zero result with no overflow,
- non-trapping operations never flag overflow,
- an overflow always comes with a result whose sign differs from rs,
- compares leave bits 31:1 clear,
- the upper-immediate form clears its low half,
- shifts leave their vacated bits zero.

Only the bench scenarios can show that the numeric results are right: signed versus unsigned ordering, the sign or zero extension chosen for each immediate opcode, and overflow at the exact wrap boundaries.

// File: rtl/risc_alu_pkg.sv
package risc_alu_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0a;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0b;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0c;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0d;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'h0f;

  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2a;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2b;

  typedef enum logic [3:0] {
    ALU_NONE, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_PASS_B
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_RT, SRC_SEXT, SRC_ZEXT, SRC_UPPER
  } src_b_e;

  typedef struct packed {
    alu_op_e op;
    src_b_e  src_b;
    logic    ovf_en;
    logic    illegal;
  } alu_ctrl_t;
endpackage

// File: rtl/risc_alu_decoder.sv
module risc_alu_decoder
  import risc_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  output alu_ctrl_t        ctrl_o
);
  always_comb begin
    ctrl_o = '{op: ALU_NONE, src_b: SRC_RT, ovf_en: 1'b0, illegal: 1'b0};
    unique case (opcode_i)
      OPC_RTYPE: begin
        unique case (funct_i)
          FN_ADD:  begin ctrl_o.op = ALU_ADD; ctrl_o.ovf_en = 1'b1; end
          FN_ADDU: ctrl_o.op = ALU_ADD;
          FN_SUB:  begin ctrl_o.op = ALU_SUB; ctrl_o.ovf_en = 1'b1; end
          FN_SUBU: ctrl_o.op = ALU_SUB;
          FN_AND:  ctrl_o.op = ALU_AND;
          FN_OR:   ctrl_o.op = ALU_OR;
          FN_NOR:  ctrl_o.op = ALU_NOR;
          FN_SLT:  ctrl_o.op = ALU_SLT;
          FN_SLTU: ctrl_o.op = ALU_SLTU;
          FN_SLL:  ctrl_o.op = ALU_SLL;
          FN_SRL:  ctrl_o.op = ALU_SRL;
          default: ctrl_o.illegal = 1'b1;
        endcase
      end
      OPC_ADDI:  begin ctrl_o.op = ALU_ADD;    ctrl_o.src_b = SRC_SEXT; ctrl_o.ovf_en = 1'b1; end
      OPC_ADDIU: begin ctrl_o.op = ALU_ADD;    ctrl_o.src_b = SRC_SEXT; end
      OPC_SLTI:  begin ctrl_o.op = ALU_SLT;    ctrl_o.src_b = SRC_SEXT; end
      OPC_SLTIU: begin ctrl_o.op = ALU_SLTU;   ctrl_o.src_b = SRC_SEXT; end
      OPC_ANDI:  begin ctrl_o.op = ALU_AND;    ctrl_o.src_b = SRC_ZEXT; end
      OPC_ORI:   begin ctrl_o.op = ALU_OR;     ctrl_o.src_b = SRC_ZEXT; end
      OPC_LUI:   begin ctrl_o.op = ALU_PASS_B; ctrl_o.src_b = SRC_UPPER; end
      default:   ctrl_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/risc_alu_operand.sv
module risc_alu_operand
  import risc_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  src_b_e           src_i,
  input  logic [XLEN-1:0]  rt_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  b_o
);
  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] sext, zext, upper;
  assign sext  = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
  assign zext  = {{PAD_W{1'b0}}, imm_i};
  assign upper = {imm_i, {PAD_W{1'b0}}};

  always_comb begin
    unique case (src_i)
      SRC_SEXT:  b_o = sext;
      SRC_ZEXT:  b_o = zext;
      SRC_UPPER: b_o = upper;
      default:   b_o = rt_i;
    endcase
  end
endmodule

// File: rtl/risc_alu_shifter.sv
module risc_alu_shifter #(
  parameter int XLEN    = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [XLEN-1:0]    data_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               left_i,
  output logic [XLEN-1:0]    data_o
);
  logic [SHAMT_W:0][XLEN-1:0] stage;
  assign stage[0] = data_i;

  // log-depth barrel: stage k moves by 2^k when amt bit k is set
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    always_comb begin
      if (!amt_i[k])   stage[k+1] = stage[k];
      else if (left_i) stage[k+1] = stage[k] << DIST;
      else             stage[k+1] = stage[k] >> DIST;
    end
  end

  assign data_o = stage[SHAMT_W];
endmodule

// File: rtl/risc_alu_exec.sv
module risc_alu_exec
  import risc_alu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SHAMT_W = 5
) (
  input  alu_ctrl_t          ctrl_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  input  logic [XLEN-1:0]    rt_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [XLEN-1:0]    result_o,
  output logic               ovf_o
);
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] sum, diff, shifted;
  logic            ovf_add, ovf_sub, lt_s, lt_u;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  assign ovf_add = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
  assign ovf_sub = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
  assign lt_s = $signed(a_i) < $signed(b_i);
  assign lt_u = a_i < b_i;

  risc_alu_shifter #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_shift (
    .data_i (rt_i),
    .amt_i  (shamt_i),
    .left_i (ctrl_i.op == ALU_SLL),
    .data_o (shifted)
  );

  always_comb begin
    unique case (ctrl_i.op)
      ALU_ADD:    result_o = sum;
      ALU_SUB:    result_o = diff;
      ALU_AND:    result_o = a_i & b_i;
      ALU_OR:     result_o = a_i | b_i;
      ALU_NOR:    result_o = ~(a_i | b_i);
      ALU_SLT:    result_o = {{(XLEN-1){1'b0}}, lt_s};
      ALU_SLTU:   result_o = {{(XLEN-1){1'b0}}, lt_u};
      ALU_SLL,
      ALU_SRL:    result_o = shifted;
      ALU_PASS_B: result_o = b_i;
      default:    result_o = '0;
    endcase
  end

  always_comb begin
    ovf_o = 1'b0;
    if (ctrl_i.ovf_en) begin
      if (ctrl_i.op == ALU_ADD)      ovf_o = ovf_add;
      else if (ctrl_i.op == ALU_SUB) ovf_o = ovf_sub;
    end
  end
endmodule

// File: rtl/risc_alu.sv
module risc_alu
  import risc_alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [OPC_W-1:0]         opcode_i,
  input  logic [FN_W-1:0]          funct_i,
  input  logic [$clog2(XLEN)-1:0]  shamt_i,
  input  logic [XLEN-1:0]          rs_i,
  input  logic [XLEN-1:0]          rt_i,
  input  logic [IMM_W-1:0]         imm_i,
  output logic [XLEN-1:0]          result_o,
  output logic                     ovf_o,
  output logic                     illegal_o
);
  localparam int SHAMT_W = $clog2(XLEN);
  localparam int PAD_W   = XLEN - IMM_W;

  alu_ctrl_t       ctrl;
  logic [XLEN-1:0] op_b;

  risc_alu_decoder u_dec (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .ctrl_o   (ctrl)
  );

  risc_alu_operand #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opb (
    .src_i (ctrl.src_b),
    .rt_i  (rt_i),
    .imm_i (imm_i),
    .b_o   (op_b)
  );

  risc_alu_exec #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_exec (
    .ctrl_i   (ctrl),
    .a_i      (rs_i),
    .b_i      (op_b),
    .rt_i     (rt_i),
    .shamt_i  (shamt_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
  );

  assign illegal_o = ctrl.illegal;

  always_comb begin
    if (illegal_o) begin
      a_r10_illegal_quiet: assert (result_o == '0 && !ovf_o)
        else $error("illegal encoding produced data");
    end
    if (!ctrl.ovf_en) begin
      a_r8_no_overflow: assert (!ovf_o)
        else $error("overflow on non-trapping op");
    end
    if (ovf_o) begin
      a_r7_ovf_sign: assert (result_o[XLEN-1] != rs_i[XLEN-1])
        else $error("overflow without sign change");
    end
    if (ctrl.op == ALU_SLT || ctrl.op == ALU_SLTU) begin
      a_r5_bool_result: assert (result_o[XLEN-1:1] == '0)
        else $error("compare result not boolean");
    end
    if (opcode_i == OPC_LUI) begin
      a_r4_upper_imm: assert (result_o == {imm_i, {PAD_W{1'b0}}})
        else $error("upper immediate misplaced");
    end
    if (ctrl.op == ALU_SLL) begin
      a_r9_sll_fill: assert ((result_o & ~({XLEN{1'b1}} << shamt_i)) == '0)
        else $error("left shift fill not zero");
    end
    if (ctrl.op == ALU_SRL) begin
      a_r9_srl_fill: assert ((result_o & ~({XLEN{1'b1}} >> shamt_i)) == '0)
        else $error("right shift fill not zero");
    end
  end
endmodule

// File: tb/risc_alu_bench.sv
module risc_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode, funct;
  logic [4:0]  shamt;
  logic [31:0] rs, rt;
  logic [15:0] imm;
  logic [31:0] result;
  logic        ovf, illegal;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  risc_alu u_risc_alu (
    .opcode_i (opcode), .funct_i (funct), .shamt_i (shamt),
    .rs_i (rs), .rt_i (rt), .imm_i (imm),
    .result_o (result), .ovf_o (ovf), .illegal_o (illegal)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (op %h fn %h)", tag, got, exp, opcode, funct);
    end
  endtask

  task automatic drive(logic [5:0] o, logic [5:0] f, logic [4:0] s,
                       logic [31:0] a, logic [31:0] b, logic [15:0] i);
    @(negedge clk);
    opcode = o; funct = f; shamt = s; rs = a; rt = b; imm = i;
    #2;
  endtask

  // reference model written from the requirements
  function automatic void model(input logic [5:0] o, input logic [5:0] f,
      input logic [4:0] s, input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] i, output logic [31:0] r, output logic v,
      output logic ill, output string tag);
    logic [31:0] se, ze;
    logic [32:0] wide;
    se = {{16{i[15]}}, i};
    ze = {16'h0, i};
    r = 0; v = 0; ill = 0; tag = "R10";
    if (o == 6'h00) begin
      case (f)
        6'h20: begin wide = {a[31], a} + {b[31], b}; r = wide[31:0]; v = wide[32] ^ wide[31]; tag = "R7"; end
        6'h21: begin r = a + b; tag = "R8"; end
        6'h22: begin wide = {a[31], a} - {b[31], b}; r = wide[31:0]; v = wide[32] ^ wide[31]; tag = "R7"; end
        6'h23: begin r = a - b; tag = "R8"; end
        6'h24: begin r = a & b; tag = "R11"; end
        6'h25: begin r = a | b; tag = "R11"; end
        6'h27: begin r = ~(a | b); tag = "R11"; end
        6'h2a: begin r = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R5"; end
        6'h2b: begin r = (a < b) ? 1 : 0; tag = "R6"; end
        6'h00: begin r = b << s; tag = "R9"; end
        6'h02: begin r = b >> s; tag = "R9"; end
        default: ill = 1;
      endcase
    end else begin
      case (o)
        6'h08: begin wide = {a[31], a} + {se[31], se}; r = wide[31:0]; v = wide[32] ^ wide[31]; tag = "R7"; end
        6'h09: begin r = a + se; tag = "R8"; end
        6'h0a: begin r = ($signed(a) < $signed(se)) ? 1 : 0; tag = "R5"; end
        6'h0b: begin r = (a < se) ? 1 : 0; tag = "R6"; end
        6'h0c: begin r = a & ze; tag = "R3"; end
        6'h0d: begin r = a | ze; tag = "R3"; end
        6'h0f: begin r = {i, 16'h0}; tag = "R4"; end
        default: ill = 1;
      endcase
    end
  endfunction

  task automatic run_model_check();
    logic [31:0] r; logic v, ill; string tag;
    model(opcode, funct, shamt, rs, rt, imm, r, v, ill, tag);
    check({tag, " result"}, result, r);
    check({tag, " ovf"}, {31'h0, ovf}, {31'h0, v});
    check("R10 illegal flag", {31'h0, illegal}, {31'h0, ill});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] legal_opc [8];
    logic [5:0] legal_fn  [11];
    legal_opc = '{6'h00, 6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d, 6'h0f};
    legal_fn  = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h27, 6'h2a, 6'h2b, 6'h00, 6'h02};
    opcode = 0; funct = 0; shamt = 0; rs = 0; rt = 0; imm = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    // idle inputs decode to a zero shift of zero
    check("R10 reset result", result, 32'h0);
    check("R10 reset illegal", {31'h0, illegal}, 32'h0);

    drive(6'h00, 6'h20, 0, 32'd5, 32'd7, 0);             check("R1 add", result, 32'd12);
    drive(6'h09, 0, 0, 32'd10, 0, 16'hffff);             check("R2 addiu -1", result, 32'd9);
    drive(6'h0d, 0, 0, 32'h0, 0, 16'h8000);              check("R3 ori zext", result, 32'h0000_8000);
    drive(6'h08, 0, 0, 32'h0, 0, 16'h8000);              check("R3 addi sext", result, 32'hffff_8000);
    drive(6'h0f, 0, 0, 32'hdead_beef, 0, 16'h1234);      check("R4 lui", result, 32'h1234_0000);
    drive(6'h00, 6'h2a, 0, 32'hffff_ffff, 32'd1, 0);     check("R5 slt signed", result, 32'd1);
    drive(6'h00, 6'h2b, 0, 32'hffff_ffff, 32'd1, 0);     check("R6 sltu", result, 32'd0);
    drive(6'h0b, 0, 0, 32'd5, 0, 16'hffff);              check("R6 sltiu sext", result, 32'd1);
    drive(6'h00, 6'h20, 0, 32'h7fff_ffff, 32'd1, 0);     check("R7 add ovf", {31'h0, ovf}, 32'd1);
    check("R7 add wrap", result, 32'h8000_0000);
    drive(6'h00, 6'h22, 0, 32'h8000_0000, 32'd1, 0);     check("R7 sub ovf", {31'h0, ovf}, 32'd1);
    drive(6'h00, 6'h22, 0, 32'h8000_0000, 32'h8000_0000, 0); check("R7 sub no ovf", {31'h0, ovf}, 32'd0);
    drive(6'h08, 0, 0, 32'h8000_0000, 0, 16'hffff);      check("R7 addi ovf", {31'h0, ovf}, 32'd1);
    drive(6'h00, 6'h21, 0, 32'h7fff_ffff, 32'd1, 0);     check("R8 addu no ovf", {31'h0, ovf}, 32'd0);
    drive(6'h00, 6'h23, 0, 32'h8000_0000, 32'd1, 0);     check("R8 subu no ovf", {31'h0, ovf}, 32'd0);
    check("R8 subu wrap", result, 32'h7fff_ffff);
    drive(6'h00, 6'h00, 5'd31, 0, 32'h1, 0);             check("R9 sll 31", result, 32'h8000_0000);
    drive(6'h00, 6'h02, 5'd31, 0, 32'h8000_0000, 0);     check("R9 srl 31", result, 32'h1);
    drive(6'h00, 6'h27, 0, 32'hf0f0_0000, 32'h0000_0f0f, 0); check("R11 nor", result, 32'h0f0f_f0f0);
    drive(6'h0c, 0, 0, 32'hffff_ffff, 0, 16'h8001);      check("R11 andi", result, 32'h0000_8001);
    drive(6'h00, 6'h26, 0, 32'h7fff_ffff, 32'h1, 0);     check("R10 bad funct", {31'h0, illegal}, 32'd1);
    check("R10 bad funct result", result, 32'h0);
    drive(6'h3f, 0, 0, 32'h7fff_ffff, 32'h1, 16'h1);     check("R10 bad opcode", {31'h0, illegal}, 32'd1);
    check("R10 bad opcode result", result, 32'h0);

    for (int n = 0; n < 3000; n++) begin
      logic [5:0] o, f;
      logic [31:0] a, b;
      int sel;
      sel = $urandom_range(0, 9);
      o = (sel == 9) ? 6'($urandom) : legal_opc[$urandom_range(0, 7)];
      f = (sel == 8) ? 6'($urandom) : legal_fn[$urandom_range(0, 10)];
      a = $urandom;
      b = $urandom;
      if ($urandom_range(0, 3) == 0) a = {a[31], {31{~a[31]}}};
      drive(o, f, 5'($urandom), a, b, 16'($urandom));
      run_model_check();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule